// File: doc/BRIEF.md
# Page Write Buffer and Self-Timed Program Sequencer

This block sits behind the serial front-end of a byte-addressed non-volatile memory. When an array-write command begins, it takes the start address. Each data byte that follows is placed in a page-sized staging buffer at the next position, counting from the address offset within the page. When the positions run past the end of the page they wrap to the start, so a later byte replaces an earlier one.

When chip select rises, the block decides whether to commit the page. It commits only if three conditions hold: the transfer ended on a byte boundary, the protection unit grants the write, and at least one byte was received. If so, it starts a self-timed programming cycle that lasts a parameterised number of clock ticks. During that cycle the in-progress flag is held high. The buffered bytes go out through a simple write port, one position per cycle in ascending order, and only positions that actually received a byte are written. A one-cycle completion pulse in the last cycle tells the status unit to clear its write-enable latch. While the cycle runs, every new command, byte and chip-select event is ignored.

Top module: `page_prog_seq`

## Requirements
- R1: After reset `progBusy`, `cycleDone` and `arrWrEn` are 0.
- R2: Data byte k of a command goes to page position (startAddr mod PAGE_BYTES + k) mod PAGE_BYTES. When more than PAGE_BYTES bytes are sent, a later byte replaces the earlier byte at the same position.
- R3: During a programming cycle `arrWrEn` pulses only for positions that received a byte. `arrWrAddr` is the start address's page base with the position in its low log2(PAGE_BYTES) bits, and positions are visited in ascending order during the first PAGE_BYTES busy cycles. All other array bytes keep their contents, and an unwritten byte reads FFh.
- R4: `progBusy` goes to 1 in the cycle after a qualifying `csRise` is sampled and stays 1 for exactly PROG_TICKS cycles.
- R5: `cycleDone` is a single-cycle pulse in the last cycle in which `progBusy` is 1.
- R6: A `csRise` sampled with `byteAligned` = 0 discards the command: no cycle starts and nothing is written.
- R7: A `csRise` sampled with `writeGrant` = 0 discards the command.
- R8: A `csRise` after a command that carried no data byte starts no cycle.
- R9: While `progBusy` is 1, `cmdStart`, `byteValid` and `csRise` have no effect. A command issued during the cycle causes no writes and does not lengthen the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Pulse: an array-write command begins; `startAddr` is valid |
| startAddr | input | ADDR_W | Start byte address of the command |
| byteValid | input | 1 | Pulse: one complete data byte on `byteData` |
| byteData | input | 8 | Data byte from the serial front-end |
| csRise | input | 1 | Pulse: chip select went inactive |
| byteAligned | input | 1 | No partial byte was pending when chip select rose |
| writeGrant | input | 1 | Protection unit allows writing the addressed page |
| progBusy | output | 1 | Programming cycle in progress |
| cycleDone | output | 1 | Pulse in the last cycle of a programming cycle |
| arrWrEn | output | 1 | Array write strobe |
| arrWrAddr | output | ADDR_W | Array write byte address |
| arrWrData | output | 8 | Array write data |

## Verification
All inputs are sampled on the rising edge. `progBusy` therefore rises one cycle after the edge that samples a qualifying `csRise`. The writes then appear in busy cycles 1 to PAGE_BYTES, and `cycleDone` is high in busy cycle PROG_TICKS. The bench advances a behavioural model at each rising edge and compares busy, done and the write port at the following falling edge, so every result is checked in the cycle it is due. Directed checks sample `progBusy` exactly one, PROG_TICKS and PROG_TICKS+1 cycles after the chip-select event. After each cycle has finished, they read back the array image built from the write port at hand-computed addresses.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [1:0] {
    PPS_IDLE    = 2'd0,
    PPS_COLLECT = 2'd1,
    PPS_PROGRAM = 2'd2
  } ppsState_e;

  typedef struct packed {
    logic loadAddr;
    logic capture;
    logic clearAll;
    logic scanEn;
  } ppsStrobe_t;

endpackage

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pps_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int PROG_TICKS = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cmdStart,
  input  logic                          byteValid,
  input  logic                          csRise,
  input  logic                          byteAligned,
  input  logic                          writeGrant,
  input  logic                          hasData,
  output ppsStrobe_t                    strobe,
  output logic [$clog2(PAGE_BYTES)-1:0] scanIdx,
  output logic                          progBusy,
  output logic                          cycleDone
);
  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int TICK_W = $clog2(PROG_TICKS + 1);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(PROG_TICKS - 1);
  localparam logic [TICK_W-1:0] SCAN_END  = TICK_W'(PAGE_BYTES);

  ppsState_e        stateQ, stateD;
  logic [TICK_W-1:0] tickQ, tickD;
  logic             collecting, lastTick, commitOk;

  assign collecting = (stateQ == PPS_COLLECT);
  assign progBusy   = (stateQ == PPS_PROGRAM);
  assign lastTick   = progBusy && (tickQ == LAST_TICK);
  assign cycleDone  = lastTick;
  assign commitOk   = byteAligned && writeGrant && hasData;
  assign scanIdx    = tickQ[IDX_W-1:0];

  always_comb begin
    stateD          = stateQ;
    tickD           = tickQ;
    strobe          = '0;
    strobe.scanEn   = progBusy && (tickQ < SCAN_END);
    unique case (stateQ)
      PPS_PROGRAM: begin
        if (lastTick) begin
          stateD          = PPS_IDLE;
          tickD           = '0;
          strobe.clearAll = 1'b1;
        end else begin
          tickD = tickQ + 1'b1;
        end
      end
      PPS_COLLECT: begin
        if (csRise) begin
          tickD = '0;
          if (commitOk) begin
            stateD = PPS_PROGRAM;
          end else begin
            stateD          = PPS_IDLE;
            strobe.clearAll = 1'b1;
          end
        end else if (cmdStart) begin
          strobe.loadAddr = 1'b1;
        end else if (byteValid) begin
          strobe.capture = 1'b1;
        end
      end
      default: begin
        if (cmdStart && !csRise) begin
          stateD          = PPS_COLLECT;
          strobe.loadAddr = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= PPS_IDLE;
      tickQ  <= '0;
    end else begin
      stateQ <= stateD;
      tickQ  <= tickD;
    end
  end

endmodule

// File: rtl/pps_datapath.sv
module pps_datapath
  import pps_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ppsStrobe_t                    strobe,
  input  logic [ADDR_W-1:0]             startAddr,
  input  logic [7:0]                    byteData,
  input  logic [$clog2(PAGE_BYTES)-1:0] scanIdx,
  output logic                          hasData,
  output logic                          arrWrEn,
  output logic [ADDR_W-1:0]             arrWrAddr,
  output logic [7:0]                    arrWrData
);
  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - IDX_W;

  logic [BASE_W-1:0]     pageBaseQ;
  logic [IDX_W-1:0]      offsetQ;
  logic [PAGE_BYTES-1:0] validQ;
  logic [7:0]            pageBuf [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageBaseQ <= '0;
      offsetQ   <= '0;
    end else if (strobe.loadAddr) begin
      pageBaseQ <= startAddr[ADDR_W-1:IDX_W];
      offsetQ   <= startAddr[IDX_W-1:0];
    end else if (strobe.capture) begin
      offsetQ   <= offsetQ + 1'b1;
    end
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    logic slotHit;
    assign slotHit = strobe.capture && (offsetQ == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (slotHit) pageBuf[i] <= byteData;
    end

    always_ff @(posedge clk) begin
      if (!rstN || strobe.loadAddr || strobe.clearAll) validQ[i] <= 1'b0;
      else if (slotHit)                                validQ[i] <= 1'b1;
    end
  end

  assign hasData   = |validQ;
  assign arrWrEn   = strobe.scanEn && validQ[scanIdx];
  assign arrWrAddr = {pageBaseQ, scanIdx};
  assign arrWrData = pageBuf[scanIdx];

endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq
  import pps_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 32,
  parameter int PROG_TICKS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              csRise,
  input  logic              byteAligned,
  input  logic              writeGrant,
  output logic              progBusy,
  output logic              cycleDone,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [7:0]        arrWrData
);
  localparam int IDX_W = $clog2(PAGE_BYTES);

  ppsStrobe_t       strobe;
  logic [IDX_W-1:0] scanIdx;
  logic             hasData;

  pps_ctrl #(
    .PAGE_BYTES(PAGE_BYTES),
    .PROG_TICKS(PROG_TICKS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdStart   (cmdStart),
    .byteValid  (byteValid),
    .csRise     (csRise),
    .byteAligned(byteAligned),
    .writeGrant (writeGrant),
    .hasData    (hasData),
    .strobe     (strobe),
    .scanIdx    (scanIdx),
    .progBusy   (progBusy),
    .cycleDone  (cycleDone)
  );

  pps_datapath #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .startAddr(startAddr),
    .byteData (byteData),
    .scanIdx  (scanIdx),
    .hasData  (hasData),
    .arrWrEn  (arrWrEn),
    .arrWrAddr(arrWrAddr),
    .arrWrData(arrWrData)
  );

endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 32,
  parameter int PROG_TICKS = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              csRise,
  input logic              progBusy,
  input logic              cycleDone,
  input logic              arrWrEn,
  input logic [ADDR_W-1:0] arrWrAddr
);
  localparam int IDX_W = $clog2(PAGE_BYTES);

  logic [31:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN || !progBusy) busyRun <= '0;
    else                    busyRun <= busyRun + 1'b1;
  end

  initial begin
    p_ticks_cover_page_r3: assert (PROG_TICKS >= PAGE_BYTES && PAGE_BYTES >= 2);
  end

  // R1: nothing is written outside a programming cycle
  p_write_only_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> progBusy);

  // R4: a cycle begins only after a chip-select rise
  p_start_after_cs_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progBusy) |-> $past(csRise));

  // R4: the cycle ends exactly after PROG_TICKS busy cycles
  p_busy_length_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(progBusy) |-> ($past(busyRun) == 32'(PROG_TICKS - 1)));

  p_busy_bounded_r4: assert property (@(posedge clk) disable iff (!rstN)
    progBusy |-> (busyRun < 32'(PROG_TICKS)));

  // R5: completion pulse is inside the cycle and ends it
  p_done_in_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> progBusy);

  p_done_ends_r5: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> (!progBusy && !cycleDone));

  // R3: writes of one cycle stay in one page and ascend
  p_same_page_r3: assert property (@(posedge clk) disable iff (!rstN)
    (progBusy && $past(progBusy)) |-> $stable(arrWrAddr[ADDR_W-1:IDX_W]));

  p_ascending_r3: assert property (@(posedge clk) disable iff (!rstN)
    (arrWrEn && $past(arrWrEn) && $past(progBusy)) |-> (arrWrAddr > $past(arrWrAddr)));

endmodule

bind page_prog_seq pps_checker #(
  .ADDR_W    (ADDR_W),
  .PAGE_BYTES(PAGE_BYTES),
  .PROG_TICKS(PROG_TICKS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .csRise   (csRise),
  .progBusy (progBusy),
  .cycleDone(cycleDone),
  .arrWrEn  (arrWrEn),
  .arrWrAddr(arrWrAddr)
);

// File: tb/page_prog_seq_tb.sv
`timescale 1ns/1ps
module page_prog_seq_tb;
  localparam int AW = 16;
  localparam int PB = 32;
  localparam int PT = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdStart = 1'b0, byteValid = 1'b0, csRise = 1'b0;
  logic          byteAligned = 1'b1, writeGrant = 1'b1;
  logic [AW-1:0] startAddr = '0;
  logic [7:0]    byteData = '0;
  logic          progBusy, cycleDone, arrWrEn;
  logic [AW-1:0] arrWrAddr;
  logic [7:0]    arrWrData;

  int checks = 0, errors = 0;
  int busyCnt = 0, doneCnt = 0, wrCnt = 0;

  // behavioural reference state
  bit       mBusy, mCollect;
  int       mTick, mBase, mOff;
  int       mBuf [PB];
  bit       mValid [PB];
  logic [7:0] dutArr [int];

  always #2.5 clk = ~clk;

  page_prog_seq #(.ADDR_W(AW), .PAGE_BYTES(PB), .PROG_TICKS(PT)) u_dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .startAddr(startAddr),
    .byteValid(byteValid), .byteData(byteData), .csRise(csRise),
    .byteAligned(byteAligned), .writeGrant(writeGrant), .progBusy(progBusy),
    .cycleDone(cycleDone), .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr),
    .arrWrData(arrWrData));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rd(input int a);
    return dutArr.exists(a) ? int'(dutArr[a]) : 32'hFF;
  endfunction

  function automatic bit anyValid();
    for (int i = 0; i < PB; i++) if (mValid[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic clearValid();
    for (int i = 0; i < PB; i++) mValid[i] = 1'b0;
  endtask

  task automatic modelEdge();
    if (!rstN) begin
      mBusy = 0; mCollect = 0; mTick = 0; clearValid();
    end else if (mBusy) begin
      if (mTick == PT - 1) begin mBusy = 0; mTick = 0; clearValid(); end
      else mTick++;
    end else if (csRise) begin
      if (mCollect && byteAligned && writeGrant && anyValid()) begin
        mBusy = 1; mTick = 0;
      end else clearValid();
      mCollect = 0;
    end else if (cmdStart) begin
      mCollect = 1; mBase = int'(startAddr) / PB; mOff = int'(startAddr) % PB; clearValid();
    end else if (byteValid && mCollect) begin
      mBuf[mOff] = int'(byteData); mValid[mOff] = 1; mOff = (mOff + 1) % PB;
    end
  endtask

  task automatic compareNow();
    bit eWr, eDone;
    eWr   = mBusy && mTick < PB && mValid[mTick];
    eDone = mBusy && mTick == PT - 1;
    chk(progBusy == mBusy, "R4 busy per-cycle", progBusy, mBusy);
    chk(cycleDone == eDone, "R5 done per-cycle", cycleDone, eDone);
    chk(arrWrEn == eWr, "R3 write enable per-cycle", arrWrEn, eWr);
    if (eWr && arrWrEn) begin
      chk(int'(arrWrAddr) == mBase * PB + mTick, "R3 write address", arrWrAddr, mBase * PB + mTick);
      chk(int'(arrWrData) == mBuf[mTick], "R2 write data", arrWrData, mBuf[mTick]);
    end
    if (progBusy) busyCnt++;
    if (cycleDone) doneCnt++;
    if (arrWrEn) begin wrCnt++; dutArr[int'(arrWrAddr)] = arrWrData; end
  endtask

  // one clock: inputs already set at a falling edge, sampled at the rising edge
  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    cmdStart = 0; byteValid = 0; csRise = 0;
    compareNow();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic sendCmd(input int a);
    cmdStart = 1; startAddr = AW'(a); step();
  endtask

  task automatic sendByte(input int d);
    byteValid = 1; byteData = 8'(d); step();
  endtask

  task automatic raiseCs(input bit al, input bit gr);
    csRise = 1; byteAligned = al; writeGrant = gr; step();
    byteAligned = 1; writeGrant = 1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    idle(4);
    rstN = 1;
    idle(1);
    // R1 reset state
    chk(progBusy == 0, "R1 busy after reset", progBusy, 0);
    chk(cycleDone == 0, "R1 done after reset", cycleDone, 0);
    chk(arrWrEn == 0, "R1 write after reset", arrWrEn, 0);

    // basic three-byte write, exact cycle timing R4 R5 R3
    sendCmd(16'h0105);
    sendByte(8'hA0); sendByte(8'hA1); sendByte(8'hA2);
    busyCnt = 0; doneCnt = 0; wrCnt = 0;
    raiseCs(1, 1);
    chk(progBusy == 1, "R4 busy one cycle after csRise", progBusy, 1);
    idle(PT - 1);
    chk(progBusy == 1, "R4 busy in last tick", progBusy, 1);
    chk(cycleDone == 1, "R5 done in last tick", cycleDone, 1);
    idle(1);
    chk(progBusy == 0, "R4 busy cleared after PROG_TICKS", progBusy, 0);
    chk(busyCnt == PT, "R4 busy length", busyCnt, PT);
    chk(doneCnt == 1, "R5 single done pulse", doneCnt, 1);
    chk(wrCnt == 3, "R3 only received positions written", wrCnt, 3);
    chk(rd(16'h0105) == 8'hA0, "R2 first byte", rd(16'h0105), 8'hA0);
    chk(rd(16'h0107) == 8'hA2, "R2 third byte", rd(16'h0107), 8'hA2);
    chk(rd(16'h0104) == 8'hFF, "R3 neighbour below untouched", rd(16'h0104), 8'hFF);
    chk(rd(16'h0108) == 8'hFF, "R3 neighbour above untouched", rd(16'h0108), 8'hFF);

    // R2 wrap inside page with overwrite: 34 bytes from offset 30
    sendCmd(16'h0F1E);
    for (int k = 0; k < 34; k++) sendByte(8'h10 + k);
    wrCnt = 0;
    raiseCs(1, 1);
    idle(PT + 2);
    chk(rd(16'h0F1E) == 8'h30, "R2 wrap overwrite pos30", rd(16'h0F1E), 8'h30);
    chk(rd(16'h0F1F) == 8'h31, "R2 wrap overwrite pos31", rd(16'h0F1F), 8'h31);
    chk(rd(16'h0F00) == 8'h12, "R2 wrapped to page start", rd(16'h0F00), 8'h12);
    chk(rd(16'h0F1D) == 8'h2F, "R2 wrapped pos29", rd(16'h0F1D), 8'h2F);
    chk(rd(16'h0F20) == 8'hFF, "R2 next page untouched", rd(16'h0F20), 8'hFF);
    chk(wrCnt == PB, "R3 full page written once each", wrCnt, PB);

    // R6 misaligned chip-select rise
    busyCnt = 0; wrCnt = 0;
    sendCmd(16'h0200); sendByte(8'h11); sendByte(8'h22);
    raiseCs(0, 1);
    idle(PT + 2);
    chk(busyCnt == 0, "R6 misaligned starts no cycle", busyCnt, 0);
    chk(rd(16'h0200) == 8'hFF, "R6 misaligned no write", rd(16'h0200), 8'hFF);

    // R7 no grant
    sendCmd(16'h0300); sendByte(8'h33);
    raiseCs(1, 0);
    idle(PT + 2);
    chk(busyCnt == 0, "R7 no grant starts no cycle", busyCnt, 0);
    chk(rd(16'h0300) == 8'hFF, "R7 no grant no write", rd(16'h0300), 8'hFF);

    // R8 address only
    sendCmd(16'h0340);
    raiseCs(1, 1);
    idle(PT + 2);
    chk(busyCnt == 0, "R8 empty command starts no cycle", busyCnt, 0);
    chk(wrCnt == 0, "R8 no writes for discarded commands", wrCnt, 0);

    // R9 command during busy is ignored
    sendCmd(16'h0400); sendByte(8'h55);
    busyCnt = 0; doneCnt = 0;
    raiseCs(1, 1);
    idle(5);
    sendCmd(16'h0500); sendByte(8'h66);
    raiseCs(1, 1);
    idle(PT + 10);
    chk(busyCnt == PT, "R9 cycle not lengthened", busyCnt, PT);
    chk(doneCnt == 1, "R9 no second cycle", doneCnt, 1);
    chk(rd(16'h0500) == 8'hFF, "R9 busy-time command not written", rd(16'h0500), 8'hFF);
    chk(rd(16'h0400) == 8'h55, "R9 running cycle completes", rd(16'h0400), 8'h55);

    // R3 partial rewrite keeps neighbours
    sendCmd(16'h0105); sendByte(8'h77);
    raiseCs(1, 1);
    idle(PT + 2);
    chk(rd(16'h0105) == 8'h77, "R3 rewritten byte", rd(16'h0105), 8'h77);
    chk(rd(16'h0106) == 8'hA1, "R3 neighbour keeps data", rd(16'h0106), 8'hA1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule